// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt inputs and presents two request lines to a processor: a normal request for prioritised, vectored service and a fast request for the few sources that must bypass arbitration. Every source carries its own trigger mode, a 3-bit priority and a 32-bit vector word, all held in registers reached over a simple single-cycle register bus. Enabling, masking, software setting and software clearing of pending state are done through write-only command words, each bit standing for one source.

Service is driven by the processor's own bus accesses. Reading the acknowledge register returns the vector of the best qualifying source and, in the same access, makes that source's priority the current level by pushing it onto a nesting stack, so only strictly more urgent sources can interrupt the handler. Writing the end-of-service register pops the stack and restores the level that was active before. When nothing qualifies, a programmable fallback vector is returned and the stack is untouched. Source 0, and any source that software redirects, goes to the fast request line and never takes part in normal arbitration. A protect bit freezes the per-source mode and vector words and records any attempt to change them.

Read data is combinational on the address in the same cycle as the read strobe; all register updates and side effects take place at the rising clock edge that ends the access.

Top module: `vpic_top`

## Requirements
- R1: After reset both request lines are low, every source is disabled, no source is pending, the nesting stack is empty, all mode and vector words read 0 and the fallback vector reads 0.
- R2: A source drives a request line only while it is both pending and enabled; writing a 1 to bit i of the enable-set word (address 0x44) enables source i, writing a 1 to bit i of the enable-clear word (0x45) disables it, and the enable mask reads back at 0x43.
- R3: The mode word of source i sits at address i (0x00 to 0x1F): bits [2:0] hold the priority and bits [5:4] the trigger, encoded 00 level active-high, 01 rising edge, 10 level active-low, 11 falling edge; the vector word of source i sits at address 0x20 + i.
- R4: A level-triggered source is pending exactly while its input is at the active level; the software set and clear words have no effect on it.
- R5: An edge-triggered source becomes pending on its selected edge or on a 1 in the pending-set word (0x46), and stops being pending on a 1 in the pending-clear word (0x47) or when it is acknowledged; a new edge in the same cycle as the acknowledge or the clear leaves it pending.
- R6: The normal request line is high while some enabled, pending, non-fast source has a priority above the current level (any priority, 0 included, when the stack is empty); reading the acknowledge word (0x40) returns the vector of the highest such priority, the lowest source number winning a tie.
- R7: A successful acknowledge pushes the winner's priority and number onto an 8-deep stack; the current source number reads at 0x41 (0 when the stack is empty).
- R8: A write to the end-of-service word (0x48) pops the stack, restoring the previous level and source number; on an empty stack it has no effect.
- R9: An acknowledge read with no qualifying source returns the fallback vector (read-write at 0x49) and leaves the stack unchanged.
- R10: Source 0 and every source whose bit is set in the fast mask drive only the fast request line and are never returned by an acknowledge; the fast mask is set at 0x4A, cleared at 0x4B and read at 0x4C, bit 0 always reading 0 and ignoring writes.
- R11: While bit 0 of the protect word (0x4D) is 1, writes to mode and vector words are ignored and a violation flag is set; reading the violation word (0x4E) returns the flag in bit 0 and clears it.
- R12: The pending state of all sources reads at 0x42, bit i for source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Raw interrupt inputs, already synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on acknowledge and violation words) |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Normal interrupt request, active high |
| fiq_o | output | 1 | Fast interrupt request, active high |

## Verification
The acknowledge of an edge-triggered source clears its pending bit while a new edge on the same input sets it, and both can land on one clock edge. The bench raises a rising-edge source on exactly the cycle whose read strobe acknowledges it, then checks that the returned vector belongs to that source and that its pending bit is still set afterwards. A randomised phase mixes pulses, acknowledges, end-of-service writes and enable changes against a reference model of levels and stack, comparing every returned vector and the request line after each step.

// File: rtl/vpic_pkg.sv
// Shared constants and types for the vectored priority interrupt controller.
// Assumes a 7-bit word address and 32-bit data on the register bus.
package vpic_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 7;

    // Trigger field: bit 0 selects edge mode, bit 1 selects inverted polarity.
    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'b00,
        TRIG_RISE   = 2'b01,
        TRIG_LVL_LO = 2'b10,
        TRIG_FALL   = 2'b11
    } trig_e;

    localparam logic [AW-1:0] A_ACK   = 7'h40;
    localparam logic [AW-1:0] A_CURID = 7'h41;
    localparam logic [AW-1:0] A_PEND  = 7'h42;
    localparam logic [AW-1:0] A_ENRD  = 7'h43;
    localparam logic [AW-1:0] A_ENSET = 7'h44;
    localparam logic [AW-1:0] A_ENCLR = 7'h45;
    localparam logic [AW-1:0] A_PSET  = 7'h46;
    localparam logic [AW-1:0] A_PCLR  = 7'h47;
    localparam logic [AW-1:0] A_EOS   = 7'h48;
    localparam logic [AW-1:0] A_SPUR  = 7'h49;
    localparam logic [AW-1:0] A_FFSET = 7'h4A;
    localparam logic [AW-1:0] A_FFCLR = 7'h4B;
    localparam logic [AW-1:0] A_FFRD  = 7'h4C;
    localparam logic [AW-1:0] A_PROT  = 7'h4D;
    localparam logic [AW-1:0] A_VIOL  = 7'h4E;
endpackage

// File: rtl/vpic_src_bank.sv
// Per-source state: mode and vector words, edge detection, pending bits,
// enable mask and fast mask. Assumes inputs are already synchronous and
// that the decoder never raises set and clear for one mask in one cycle.
module vpic_src_bank
    import vpic_pkg::*;
#(
    parameter int unsigned NSRC = 32,
    parameter int unsigned PW   = 3,
    parameter int unsigned IW   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src_i,
    input  logic                      mode_we,
    input  logic                      vec_we,
    input  logic [IW-1:0]             wr_idx,
    input  logic [DW-1:0]             wdata,
    input  logic [NSRC-1:0]           en_set,
    input  logic [NSRC-1:0]           en_clr,
    input  logic [NSRC-1:0]           pnd_set,
    input  logic [NSRC-1:0]           pnd_clr,
    input  logic [NSRC-1:0]           ff_set,
    input  logic [NSRC-1:0]           ff_clr,
    input  logic                      ack_take,
    input  logic [IW-1:0]             ack_idx,
    output logic [NSRC-1:0]           pend_o,
    output logic [NSRC-1:0]           en_o,
    output logic [NSRC-1:0]           ff_o,
    output logic [NSRC-1:0][PW-1:0]   prio_o,
    output logic [NSRC-1:0][1:0]      trig_o,
    output logic [NSRC-1:0][DW-1:0]   vec_o
);
    logic [NSRC-1:0] en_q, ff_q;

    // Enable and fast masks, updated by set/clear command words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            ff_q <= '0;
        end else begin
            en_q <= (en_q | en_set) & ~en_clr;
            ff_q <= (ff_q | ff_set) & ~ff_clr;
        end
    end

    assign en_o = en_q;
    assign ff_o = ff_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic [PW-1:0] prio_q;
        trig_e         trig_q;
        logic [DW-1:0] vec_q;
        logic          prev_q, epend_q;
        logic          sel, ack_hit, is_edge, inv, edge_hit;

        assign sel     = (wr_idx == IW'(g));
        assign ack_hit = ack_take && (ack_idx == IW'(g));
        assign is_edge = trig_q[0];
        assign inv     = trig_q[1];

        // Edge detector on the selected polarity.
        always_comb edge_hit = is_edge && (inv ? (prev_q && !src_i[g])
                                               : (!prev_q && src_i[g]));

        // Mode word: priority and trigger selection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
                trig_q <= TRIG_LVL_HI;
            end else if (mode_we && sel) begin
                prio_q <= wdata[PW-1:0];
                trig_q <= trig_e'(wdata[5:4]);
            end
        end

        // Vector word returned on acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)            vec_q <= '0;
            else if (vec_we && sel) vec_q <= wdata;
        end

        // Edge pending latch; a fresh edge or set wins over clear and acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q  <= 1'b0;
                epend_q <= 1'b0;
            end else begin
                prev_q  <= src_i[g];
                epend_q <= is_edge ? ((epend_q && !(pnd_clr[g] || ack_hit))
                                      || edge_hit || pnd_set[g]) : 1'b0;
            end
        end

        assign pend_o[g] = is_edge ? epend_q : (src_i[g] ^ inv);
        assign prio_o[g] = prio_q;
        assign trig_o[g] = trig_q;
        assign vec_o[g]  = vec_q;

        // R5: acknowledge without a new edge or set drops the pending bit.
        p_ack_clears_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_hit && trig_q == TRIG_RISE && !src_i[g] && !pnd_set[g] && !mode_we)
            |=> !pend_o[g])
            else $error("acknowledged edge source stayed pending");
    end
endmodule

// File: rtl/vpic_arbiter.sv
// Combinational priority pick: highest priority strictly above the current
// level (any level when the stack is empty), lowest index on a tie.
// Assumes candidate bits are already qualified by enable and fast mask.
module vpic_arbiter #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned PW   = 3,
    parameter int unsigned IW   = 5
) (
    input  logic [NSRC-1:0]         cand_i,
    input  logic [NSRC-1:0][PW-1:0] prio_i,
    input  logic                    thr_valid,
    input  logic [PW-1:0]           thr_lvl,
    output logic                    win_valid,
    output logic [IW-1:0]           win_idx,
    output logic [PW-1:0]           win_prio
);
    // Linear scan; strict comparison keeps the lower index on ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand_i[i] && (!thr_valid || prio_i[i] > thr_lvl)
                && (!win_valid || prio_i[i] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                win_prio  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/vpic_nest_stack.sv
// Nesting stack of (level, source) pairs. Assumes push and pop are never
// requested in the same cycle and DEPTH is at least the number of levels.
module vpic_nest_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PW    = 3,
    parameter int unsigned IW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_lvl,
    input  logic [IW-1:0] push_id,
    input  logic          pop,
    output logic          empty_o,
    output logic          full_o,
    output logic [PW-1:0] top_lvl_o,
    output logic [IW-1:0] top_id_o
);
    localparam int unsigned SW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned DPW = $clog2(DEPTH + 1);

    logic [DPW-1:0] cnt_q, cnt_m1;
    logic [PW-1:0]  lvl_q [DEPTH];
    logic [IW-1:0]  id_q  [DEPTH];

    assign cnt_m1  = cnt_q - DPW'(1);
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == DPW'(DEPTH));

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (push && !full_o)  cnt_q <= cnt_q + DPW'(1);
        else if (pop && !empty_o)  cnt_q <= cnt_m1;
    end

    // Entry storage, written on push only.
    always_ff @(posedge clk) begin
        if (push && !full_o) begin
            lvl_q[cnt_q[SW-1:0]] <= push_lvl;
            id_q[cnt_q[SW-1:0]]  <= push_id;
        end
    end

    assign top_lvl_o = empty_o ? '0 : lvl_q[cnt_m1[SW-1:0]];
    assign top_id_o  = empty_o ? '0 : id_q[cnt_m1[SW-1:0]];

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full_o) else $error("push on full stack");

    p_push_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full_o) |=> (!empty_o && top_lvl_o == $past(push_lvl)
                               && top_id_o == $past(push_id)))
        else $error("pushed entry not on top");

    p_pop_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty_o) |=> (cnt_q == $past(cnt_m1)))
        else $error("pop did not reduce depth");
endmodule

// File: rtl/vpic_top.sv
// Vectored priority interrupt controller: register decode, request lines,
// acknowledge and end-of-service handling. Assumes NSRC <= 32, PW <= 4 and
// DEPTH >= NPRIO; read data is combinational within the strobe cycle.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NPRIO = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [6:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            irq_o,
    output logic            fiq_o
);
    localparam int unsigned PW = $clog2(NPRIO);
    localparam int unsigned IW = $clog2(NSRC);
    localparam logic [5:0]  NSRC6 = 6'(NSRC);
    localparam logic [NSRC-1:0] SRC0 = NSRC'(1);

    logic                    in_mode, in_vec, mode_we, vec_we;
    logic [IW-1:0]           ridx;
    logic [NSRC-1:0]         en_set, en_clr, pnd_set, pnd_clr, ff_set, ff_clr;
    logic [NSRC-1:0]         pend, en, ff, fast_mask, active, cand;
    logic [NSRC-1:0][PW-1:0] prio;
    logic [NSRC-1:0][1:0]    trig;
    logic [NSRC-1:0][DW-1:0] vec;
    logic                    win_valid, ack_rd, ack_take, eos;
    logic [IW-1:0]           win_idx;
    logic [PW-1:0]           win_prio, stk_lvl;
    logic [IW-1:0]           stk_id;
    logic                    stk_empty, stk_full;
    logic [DW-1:0]           spur_q;
    logic                    prot_q, viol_q, prot_hit;

    // Address decode for per-source regions and command words.
    always_comb begin
        ridx     = bus_addr[IW-1:0];
        in_mode  = (bus_addr[6:5] == 2'b00) && ({1'b0, bus_addr[4:0]} < NSRC6);
        in_vec   = (bus_addr[6:5] == 2'b01) && ({1'b0, bus_addr[4:0]} < NSRC6);
        prot_hit = bus_wr && prot_q && (in_mode || in_vec);
        mode_we  = bus_wr && in_mode && !prot_q;
        vec_we   = bus_wr && in_vec && !prot_q;
        en_set   = (bus_wr && bus_addr == A_ENSET) ? bus_wdata[NSRC-1:0] : '0;
        en_clr   = (bus_wr && bus_addr == A_ENCLR) ? bus_wdata[NSRC-1:0] : '0;
        pnd_set  = (bus_wr && bus_addr == A_PSET)  ? bus_wdata[NSRC-1:0] : '0;
        pnd_clr  = (bus_wr && bus_addr == A_PCLR)  ? bus_wdata[NSRC-1:0] : '0;
        ff_set   = (bus_wr && bus_addr == A_FFSET) ? (bus_wdata[NSRC-1:0] & ~SRC0) : '0;
        ff_clr   = (bus_wr && bus_addr == A_FFCLR) ? (bus_wdata[NSRC-1:0] & ~SRC0) : '0;
        ack_rd   = bus_rd && (bus_addr == A_ACK);
        eos      = bus_wr && (bus_addr == A_EOS);
    end

    vpic_src_bank #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .mode_we(mode_we), .vec_we(vec_we), .wr_idx(ridx), .wdata(bus_wdata),
        .en_set(en_set), .en_clr(en_clr), .pnd_set(pnd_set), .pnd_clr(pnd_clr),
        .ff_set(ff_set), .ff_clr(ff_clr),
        .ack_take(ack_take), .ack_idx(win_idx),
        .pend_o(pend), .en_o(en), .ff_o(ff),
        .prio_o(prio), .trig_o(trig), .vec_o(vec)
    );

    // Split active sources between the fast line and normal arbitration.
    always_comb begin
        fast_mask = ff | SRC0;
        active    = pend & en;
        cand      = active & ~fast_mask;
    end

    vpic_arbiter #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb (
        .cand_i(cand), .prio_i(prio),
        .thr_valid(!stk_empty), .thr_lvl(stk_lvl),
        .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
    );

    assign ack_take = ack_rd && win_valid;

    vpic_nest_stack #(.DEPTH(DEPTH), .PW(PW), .IW(IW)) u_stk (
        .clk(clk), .rst_n(rst_n),
        .push(ack_take), .push_lvl(win_prio), .push_id(win_idx), .pop(eos),
        .empty_o(stk_empty), .full_o(stk_full), .top_lvl_o(stk_lvl), .top_id_o(stk_id)
    );

    assign irq_o = win_valid;
    assign fiq_o = |(active & fast_mask);

    // Fallback vector and protect bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spur_q <= '0;
            prot_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_SPUR) spur_q <= bus_wdata;
            if (bus_addr == A_PROT) prot_q <= bus_wdata[0];
        end
    end

    // Sticky violation flag, cleared when read.
    always_ff @(posedge clk) begin
        if (!rst_n)                            viol_q <= 1'b0;
        else if (prot_hit)                     viol_q <= 1'b1;
        else if (bus_rd && bus_addr == A_VIOL) viol_q <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (in_mode) begin
            bus_rdata[PW-1:0] = prio[ridx];
            bus_rdata[5:4]    = trig[ridx];
        end else if (in_vec) begin
            bus_rdata = vec[ridx];
        end else begin
            case (bus_addr)
                A_ACK:   bus_rdata = win_valid ? vec[win_idx] : spur_q;
                A_CURID: bus_rdata[IW-1:0] = stk_id;
                A_PEND:  bus_rdata[NSRC-1:0] = pend;
                A_ENRD:  bus_rdata[NSRC-1:0] = en;
                A_FFRD:  bus_rdata[NSRC-1:0] = ff;
                A_SPUR:  bus_rdata = spur_q;
                A_PROT:  bus_rdata[0] = prot_q;
                A_VIOL:  bus_rdata[0] = viol_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    p_ack_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (!stk_empty && stk_lvl == $past(win_prio)))
        else $error("acknowledge did not raise the level");

    p_above_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !stk_empty) |-> (win_prio > stk_lvl))
        else $error("winner not above current level");

    p_spur_keeps_stack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !win_valid) |=> ($stable(stk_empty) && $stable(stk_lvl)))
        else $error("fallback acknowledge changed the stack");

    p_eos_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && stk_empty) |=> stk_empty)
        else $error("end of service on empty stack changed it");

    p_protect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prot_hit |=> ($stable(prio) && $stable(trig) && $stable(vec) && viol_q))
        else $error("protected write took effect");

    p_stack_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !win_valid)
        else $error("candidate above a full stack");
endmodule

// File: tb/sim_vpic_top.sv
// Self-checking bench: directed corner cases plus a seeded random phase
// compared against a reference model of pending state, levels and stack.
module sim_vpic_top;
    localparam logic [6:0] ACK = 7'h40, CURID = 7'h41, PEND = 7'h42, ENRD = 7'h43;
    localparam logic [6:0] ENSET = 7'h44, ENCLR = 7'h45, PSET = 7'h46, PCLR = 7'h47;
    localparam logic [6:0] EOS = 7'h48, SPUR = 7'h49, FFSET = 7'h4A, FFCLR = 7'h4B;
    localparam logic [6:0] FFRD = 7'h4C, PROT = 7'h4D, VIOL = 7'h4E;
    localparam logic [31:0] SPV = 32'h5A5A_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model for the random phase
    int          m_prio [32];
    logic [31:0] m_vec  [32];
    logic [31:0] m_pend, m_en;
    int          m_stk  [8];
    int          m_sp;

    always #10 clk = ~clk;

    vpic_top u0 (.clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
                 .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                 .irq_o(irq_o), .fiq_o(fiq_o));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic drive(input int i, input logic v);
        @(negedge clk); src[i] = v;
        @(posedge clk); #1;
    endtask

    task automatic pulse(input int i);
        drive(i, 1'b1);
        drive(i, 1'b0);
    endtask

    function automatic logic [31:0] vv(input int i);
        return 32'hC0DE_0000 | i;
    endfunction

    task automatic cfg(input int i, input logic [1:0] t, input int p, input logic [31:0] v);
        wr(7'(i), {26'd0, t, 1'b0, 3'(p)});
        wr(7'(32 + i), v);
    endtask

    function automatic int exp_winner();
        int w = -1;
        for (int i = 1; i < 32; i++) begin
            if (m_pend[i] && m_en[i] && (m_sp == 0 || m_prio[i] > m_stk[m_sp-1])
                && (w < 0 || m_prio[i] > m_prio[w])) w = i;
        end
        return w;
    endfunction

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R1 fiq after reset", {31'd0, fiq_o}, 32'd0);
        rchk("R1 current id", CURID, 32'd0);
        rchk("R1 pending", PEND, 32'd0);
        rchk("R1 enables", ENRD, 32'd0);
        rchk("R1 mode word", 7'd3, 32'd0);
        rchk("R1 R9 ack returns reset fallback", ACK, 32'd0);

        // R3 R4 level active-high
        cfg(3, 2'b00, 2, vv(3));
        wr(ENSET, 32'h8);
        rchk("R3 mode readback", 7'd3, 32'h2);
        drive(3, 1'b1);
        chk("R4 level high raises irq", {31'd0, irq_o}, 32'd1);
        rchk("R4 level pending", PEND, 32'h8);
        drive(3, 1'b0);
        chk("R4 level drop lowers irq", {31'd0, irq_o}, 32'd0);
        wr(PSET, 32'h8);
        rchk("R4 set ignored on level", PEND, 32'h0);
        wr(ENCLR, 32'h8);

        // R3 level active-low, R2 enable gating
        cfg(4, 2'b10, 1, vv(4));
        rchk("R3 active-low pending", PEND, 32'h10);
        chk("R2 disabled source silent", {31'd0, irq_o}, 32'd0);
        wr(ENSET, 32'h10);
        chk("R2 enabled source raises irq", {31'd0, irq_o}, 32'd1);
        rchk("R2 R12 enable readback", ENRD, 32'h10);
        drive(4, 1'b1);
        rchk("R3 active-low released", PEND, 32'h0);
        wr(ENCLR, 32'h10);
        rchk("R2 enable cleared", ENRD, 32'h0);

        // R5 rising and falling edges, software set/clear
        cfg(5, 2'b01, 4, vv(5));
        pulse(5);
        rchk("R5 rising edge latched", PEND, 32'h20);
        chk("R2 pending but disabled", {31'd0, irq_o}, 32'd0);
        wr(PCLR, 32'h20);
        rchk("R5 software clear", PEND, 32'h0);
        wr(PSET, 32'h20);
        rchk("R5 software set", PEND, 32'h20);
        wr(PCLR, 32'h20);
        cfg(6, 2'b11, 4, vv(6));
        drive(6, 1'b1);
        rchk("R3 falling mode ignores rise", PEND, 32'h0);
        drive(6, 1'b0);
        rchk("R3 falling edge latched", PEND, 32'h40);
        wr(PCLR, 32'h40);

        // R6 R7 R8 R9 arbitration, tie, fallback
        wr(SPUR, SPV);
        rchk("R9 fallback readback", SPUR, SPV);
        cfg(7, 2'b01, 5, vv(7));
        cfg(8, 2'b01, 5, vv(8));
        cfg(9, 2'b01, 3, vv(9));
        wr(ENSET, 32'h380);
        pulse(7); pulse(8); pulse(9);
        chk("R6 irq with candidates", {31'd0, irq_o}, 32'd1);
        rchk("R6 tie goes to lower number", ACK, vv(7));
        rchk("R7 current id after ack", CURID, 32'd7);
        chk("R6 equal level does not interrupt", {31'd0, irq_o}, 32'd0);
        rchk("R9 nothing qualifies", ACK, SPV);
        rchk("R9 stack unchanged", CURID, 32'd7);
        wr(EOS, 0);
        rchk("R8 pop to empty", CURID, 32'd0);
        chk("R8 irq back after pop", {31'd0, irq_o}, 32'd1);
        rchk("R6 next equal source", ACK, vv(8));
        wr(EOS, 0);
        rchk("R6 lower priority last", ACK, vv(9));
        wr(EOS, 0);
        wr(EOS, 0);
        rchk("R8 pop on empty ignored", CURID, 32'd0);
        chk("R6 irq idle", {31'd0, irq_o}, 32'd0);
        rchk("R5 ack cleared edge pendings", PEND, 32'h0);

        // R7 R8 nesting
        cfg(10, 2'b01, 2, vv(10));
        cfg(11, 2'b01, 6, vv(11));
        cfg(12, 2'b01, 4, vv(12));
        wr(ENSET, 32'h1C00);
        pulse(10);
        rchk("R7 outer ack", ACK, vv(10));
        pulse(11);
        chk("R7 higher nests", {31'd0, irq_o}, 32'd1);
        rchk("R7 inner ack", ACK, vv(11));
        rchk("R7 inner id", CURID, 32'd11);
        pulse(12);
        chk("R7 lower than inner blocked", {31'd0, irq_o}, 32'd0);
        wr(EOS, 0);
        rchk("R8 restores outer id", CURID, 32'd10);
        chk("R8 restored level admits 4", {31'd0, irq_o}, 32'd1);
        rchk("R7 middle ack", ACK, vv(12));
        wr(EOS, 0); wr(EOS, 0);
        rchk("R8 fully unwound", CURID, 32'd0);

        // R6 priority 0 qualifies on an empty stack
        cfg(16, 2'b01, 0, vv(16));
        wr(ENSET, 32'h1_0000);
        pulse(16);
        chk("R6 level 0 when idle", {31'd0, irq_o}, 32'd1);
        rchk("R6 level 0 ack", ACK, vv(16));
        chk("R6 level 0 masked after ack", {31'd0, irq_o}, 32'd0);
        wr(EOS, 0);

        // R5 acknowledge and new edge in one cycle
        cfg(13, 2'b01, 1, vv(13));
        wr(ENSET, 32'h2000);
        pulse(13);
        @(negedge clk); src[13] = 1'b1; bus_rd = 1'b1; bus_addr = ACK; #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
        chk("R5 ack in edge cycle vector", d, vv(13));
        rchk("R5 new edge survives ack", PEND, 32'h2000);
        chk("R7 same level blocked", {31'd0, irq_o}, 32'd0);
        wr(EOS, 0);
        rchk("R5 re-ack", ACK, vv(13));
        rchk("R5 cleared without edge", PEND, 32'h0);
        wr(EOS, 0);
        drive(13, 1'b0);

        // R10 fast line
        cfg(0, 2'b01, 0, vv(0));
        wr(ENSET, 32'h1);
        pulse(0);
        chk("R10 source 0 on fast line", {31'd0, fiq_o}, 32'd1);
        chk("R10 source 0 not on normal", {31'd0, irq_o}, 32'd0);
        rchk("R10 source 0 never acknowledged", ACK, SPV);
        wr(PCLR, 32'h1);
        chk("R10 fast cleared by software", {31'd0, fiq_o}, 32'd0);
        cfg(14, 2'b01, 7, vv(14));
        wr(ENSET, 32'h4000);
        wr(FFSET, 32'h4001);
        rchk("R10 fast mask readback", FFRD, 32'h4000);
        pulse(14);
        chk("R10 forced source on fast", {31'd0, fiq_o}, 32'd1);
        chk("R10 forced source off normal", {31'd0, irq_o}, 32'd0);
        wr(PCLR, 32'h4000);
        chk("R10 forced cleared", {31'd0, fiq_o}, 32'd0);
        wr(FFCLR, 32'h4000);
        rchk("R10 fast mask cleared", FFRD, 32'h0);
        pulse(14);
        chk("R10 back on normal", {31'd0, irq_o}, 32'd1);
        chk("R10 off fast", {31'd0, fiq_o}, 32'd0);
        rchk("R10 normal ack", ACK, vv(14));
        wr(EOS, 0);

        // R11 write protection
        wr(PROT, 32'h1);
        rchk("R11 protect readback", PROT, 32'h1);
        wr(7'd15, 32'h7);
        rchk("R11 mode write ignored", 7'd15, 32'h0);
        wr(7'd47, 32'hDEAD);
        rchk("R11 vector write ignored", 7'd47, 32'h0);
        rchk("R11 violation flagged", VIOL, 32'h1);
        rchk("R11 flag cleared by read", VIOL, 32'h0);
        wr(PROT, 32'h0);
        wr(7'd15, 32'h7);
        rchk("R11 write after unprotect", 7'd15, 32'h7);
        rchk("R11 no violation unprotected", VIOL, 32'h0);

        // Random phase: rising-edge sources 1..31
        @(negedge clk); src = '0;
        @(posedge clk); #1;
        wr(ENCLR, 32'hFFFF_FFFF);
        for (int i = 1; i < 32; i++) begin
            m_prio[i] = int'($urandom % 8);
            m_vec[i]  = $urandom;
            cfg(i, 2'b01, m_prio[i], m_vec[i]);
        end
        wr(PCLR, 32'hFFFF_FFFF);
        m_pend = '0;
        m_sp = 0;
        m_en = $urandom & 32'hFFFF_FFFE;
        wr(ENSET, m_en);
        rchk("R12 random start pending", PEND, 32'h0);
        for (int k = 0; k < 500; k++) begin
            int op;
            int w;
            op = int'($urandom % 5);
            case (op)
                0: begin
                    int i;
                    i = 1 + int'($urandom % 31);
                    pulse(i);
                    m_pend[i] = 1'b1;
                end
                1, 2: begin
                    w = exp_winner();
                    rd(ACK, d);
                    chk("R6 random ack vector", d, (w < 0) ? SPV : m_vec[w]);
                    if (w >= 0) begin
                        m_stk[m_sp] = m_prio[w];
                        m_sp++;
                        m_pend[w] = 1'b0;
                    end
                end
                3: begin
                    wr(EOS, 0);
                    if (m_sp > 0) m_sp--;
                end
                default: begin
                    logic [31:0] r;
                    r = $urandom & 32'hFFFF_FFFE;
                    if ($urandom % 2 == 0) begin wr(ENSET, r); m_en = m_en | r; end
                    else begin wr(ENCLR, r); m_en = m_en & ~r; end
                end
            endcase
            w = exp_winner();
            chk("R6 random irq line", {31'd0, irq_o}, {31'd0, (w >= 0)});
        end
        rchk("R12 random final pending", PEND, m_pend);
        rchk("R2 random final enables", ENRD, m_en);

        done = 1;
        report();
        $finish;
    end
endmodule